// File: doc/BRIEF.md
# SPI PSRAM Line Cache

This block gives a host a byte-wide read and write port onto a serial pseudo-static RAM. The memory is reached over a single-lane SPI bus in mode 0, with the most significant bit first. A direct-mapped cache of 16 lines, each 16 bytes wide, sits in front of the memory. A read that misses fetches the whole aligned line in one bus transaction. That transaction is a fast-read opcode, a 24-bit line address and one dummy byte, followed by the data bytes. The block fills the cache line and then answers the host. A read that hits is answered from the cache on the next clock, with no bus activity. A write goes straight to the memory as a single-byte program transaction. If the target line is cached, the cached copy is updated at the same time. A write never loads a line.

Requests enter on a valid/ready channel. The host keeps `req_valid` and the request fields stable until it sees `req_ready` high on a rising edge; that edge is the acceptance. `req_ready` is low while a fill or a write is on the bus, and during the start-up sequence. Read results come back on a one-cycle `rsp_valid` pulse. The response channel cannot be held back, so the host must take the data in the cycle it appears. Writes produce no response. The write is complete when `req_ready` returns high.

After reset the block sends a reset-enable command and then a device-reset command, each in its own chip-select pulse. Only then does it accept host requests. Parameters set the SCK divider, the clock period and the chip-select time limit. Elaboration fails if a full line fill would hold chip-select low longer than that limit.

Top module: `psram_line_cache`

## Requirements
- R1: Reset state and start-up. While reset is held, `spi_cs_n` is 1, `spi_sck` is 0 and every cache line is invalid. After reset the block sends the byte 0x66 alone in one chip-select pulse, then 0x99 alone in a second pulse. `req_ready` stays 0 until both have finished.
- R2: A read miss makes exactly one SPI transaction of 21 bytes, shifted MSB first in mode 0 (sampled on the rising SCK edge). The bytes are: opcode 0x0B; the 24-bit address with its low 4 bits cleared, most significant byte first; one dummy byte of 0x00; then 16 data bytes read from MISO.
- R3: On a read miss, `req_ready` drops in the cycle after acceptance and stays low until the fill ends. `rsp_valid` then pulses once, and `rsp_rdata` carries the byte at the requested offset of the fetched line.
- R4: A read that hits gives `rsp_valid` with the cached byte on the first clock after acceptance. It makes no SPI transaction, and `req_ready` stays high so hits can be accepted back to back.
- R5: The cache is direct-mapped. Address bits [7:4] select the line, and bits [22:8] are the tag. A fill replaces whatever line held the same index. A later read of the evicted address misses again.
- R6: A write makes one 5-byte transaction: opcode 0x02, the 24-bit byte address most significant byte first, then the data byte. A cached copy of that byte is updated. An uncached line is not loaded, so a later read of it misses and returns the written value. A write gives no `rsp_valid`.
- R7: `spi_cs_n` never stays low longer than the 8 us limit. With the default parameters a line fill keeps it low for about 2.7 us.
- R8: Between two transactions `spi_cs_n` stays high for at least one full SCK period, and SCK is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 23 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 8 | Read data |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
The memory model on the bench returns a byte computed from each address, so every offset within a line has its own value. A wrong byte position or a shifted fill therefore shows up as a wrong response. Reads are issued in four patterns:
- A cold miss followed by hits at other offsets of the same line, which separates the fill path from the hit path and checks the hit latency.
- Two addresses that share an index but differ in tag, read alternately, which shows whether the tag compare evicts correctly.
- Writes to a cached line and to an uncached line, which separate the update-in-place path from the no-allocate path.
- The highest address, which checks the full tag width.

The bus monitor records every transaction. It also measures the chip-select low and high times to check the timing limits.

// File: rtl/psram_cache_pkg.sv
package psram_cache_pkg;
  localparam logic [7:0] OP_FAST_READ = 8'h0B;
  localparam logic [7:0] OP_PROGRAM   = 8'h02;
  localparam logic [7:0] OP_RST_EN    = 8'h66;
  localparam logic [7:0] OP_RST       = 8'h99;
  localparam int         HDR_BYTES    = 5;

  typedef enum logic [2:0] {
    ST_BOOT0, ST_BOOT0_W, ST_BOOT1, ST_BOOT1_W, ST_IDLE, ST_FILL, ST_WRITE
  } ctl_state_e;

  typedef enum logic [1:0] {SP_IDLE, SP_SHIFT, SP_GAP} spi_state_e;
endpackage

// File: rtl/psram_spi_engine.sv
module psram_spi_engine
  import psram_cache_pkg::*;
#(
  parameter int SCK_DIV      = 2,
  parameter int MAX_RX       = 16,
  parameter int CS_LIMIT_CYC = 2000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [39:0]                      tx_frame,
  input  logic [2:0]                       tx_bytes,
  input  logic [$clog2(MAX_RX+1)-1:0]      rx_bytes,
  output logic                             done,
  output logic                             rx_valid,
  output logic [7:0]                       rx_data,
  output logic                             sck,
  output logic                             cs_n,
  output logic                             mosi,
  input  logic                             miso
);
  localparam int DIV_W  = $clog2(SCK_DIV + 1);
  localparam int BIT_W  = $clog2((HDR_BYTES + MAX_RX) * 8 + 1);
  localparam int GAP    = 2 * SCK_DIV;
  localparam int GAP_W  = $clog2(GAP + 1);
  localparam int LOW_W  = $clog2(CS_LIMIT_CYC + 2);

  spi_state_e       st_q;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q, total_q, txbits_q;
  logic [GAP_W-1:0] gap_q;
  logic [39:0]      sr_q;
  logic [6:0]       rx_sr_q;
  logic             half_tick;

  assign half_tick = (div_q == DIV_W'(SCK_DIV - 1));
  assign mosi      = sr_q[39];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SP_IDLE;
      cs_n     <= 1'b1;
      sck      <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      total_q  <= '0;
      txbits_q <= '0;
      gap_q    <= '0;
      sr_q     <= '0;
      rx_sr_q  <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      done     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      done     <= 1'b0;
      unique case (st_q)
        SP_IDLE: if (start) begin
          st_q     <= SP_SHIFT;
          cs_n     <= 1'b0;
          sr_q     <= tx_frame;
          bit_q    <= '0;
          div_q    <= '0;
          txbits_q <= BIT_W'(tx_bytes) << 3;
          total_q  <= (BIT_W'(tx_bytes) + BIT_W'(rx_bytes)) << 3;
        end
        SP_SHIFT: begin
          if (half_tick) begin
            div_q <= '0;
            if (!sck) begin
              sck     <= 1'b1;
              rx_sr_q <= {rx_sr_q[5:0], miso};
              if (bit_q >= txbits_q && bit_q[2:0] == 3'd7) begin
                rx_valid <= 1'b1;
                rx_data  <= {rx_sr_q, miso};
              end
            end else begin
              sck   <= 1'b0;
              sr_q  <= {sr_q[38:0], 1'b0};
              bit_q <= bit_q + 1'b1;
              if (bit_q == total_q - 1'b1) begin
                st_q  <= SP_GAP;
                cs_n  <= 1'b1;
                gap_q <= '0;
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        SP_GAP: begin
          if (gap_q == GAP_W'(GAP - 1)) begin
            st_q <= SP_IDLE;
            done <= 1'b1;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= SP_IDLE;
      endcase
    end
  end

  logic [LOW_W-1:0] low_cnt_q;
  logic [GAP_W-1:0] high_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q  <= '0;
      high_cnt_q <= GAP_W'(GAP);
    end else if (cs_n) begin
      low_cnt_q  <= '0;
      if (high_cnt_q != GAP_W'(GAP)) high_cnt_q <= high_cnt_q + 1'b1;
    end else begin
      high_cnt_q <= '0;
      if (low_cnt_q != LOW_W'(CS_LIMIT_CYC + 1)) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  // R7
  cs_low_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (low_cnt_q < LOW_W'(CS_LIMIT_CYC)));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (high_cnt_q >= GAP_W'(GAP)));

  // R8
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
endmodule

// File: rtl/psram_line_store.sv
module psram_line_store #(
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 16,
  parameter int TAG_W      = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(LINES)-1:0]      lk_idx,
  input  logic [TAG_W-1:0]              lk_tag,
  input  logic [$clog2(LINE_BYTES)-1:0] lk_off,
  output logic                          lk_hit,
  output logic [7:0]                    lk_data,
  input  logic                          wr_en,
  input  logic [$clog2(LINES)-1:0]      wr_idx,
  input  logic [$clog2(LINE_BYTES)-1:0] wr_off,
  input  logic [7:0]                    wr_data,
  input  logic                          tag_we,
  input  logic [$clog2(LINES)-1:0]      tag_idx,
  input  logic [TAG_W-1:0]              tag_val,
  input  logic                          tag_valid
);
  logic [7:0]       data_q [LINES][LINE_BYTES];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_q;

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data = data_q[lk_idx][lk_off];

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx][wr_off] <= wr_data;
    if (tag_we) tag_q[tag_idx] <= tag_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (tag_we) valid_q[tag_idx] <= tag_valid;
  end
endmodule

// File: rtl/psram_line_cache.sv
module psram_line_cache
  import psram_cache_pkg::*;
#(
  parameter int ADDR_W        = 23,
  parameter int LINES         = 16,
  parameter int LINE_BYTES    = 16,
  parameter int SCK_DIV       = 2,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int CS_MAX_PS     = 8000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int OFF_W        = $clog2(LINE_BYTES);
  localparam int IDX_W        = $clog2(LINES);
  localparam int TAG_W        = ADDR_W - OFF_W - IDX_W;
  localparam int RXC_W        = $clog2(LINE_BYTES + 1);
  localparam int FILL_CYC     = (HDR_BYTES + LINE_BYTES) * 8 * 2 * SCK_DIV + 2;
  localparam int CS_LIMIT_CYC = CS_MAX_PS / CLK_PERIOD_PS;
  localparam longint FILL_PS  = longint'(FILL_CYC) * longint'(CLK_PERIOD_PS);

  generate
    if (FILL_PS > longint'(CS_MAX_PS)) begin : g_cs_budget_bad
      $error("line fill exceeds chip-select low-time budget");
    end
    if (ADDR_W > 24) begin : g_addr_bad
      $error("address wider than the 24-bit bus address");
    end
  endgenerate

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [23:0]      req_a24, line_a24;
  assign req_off  = req_addr[OFF_W-1:0];
  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_a24  = 24'(req_addr);
  assign line_a24 = req_a24 & ~24'(LINE_BYTES - 1);

  ctl_state_e       st_q;
  logic             eng_start_q, eng_done, eng_rx_valid;
  logic [7:0]       eng_rx_data;
  logic [39:0]      frame_q;
  logic [2:0]       ntx_q;
  logic [RXC_W-1:0] nrx_q;
  logic [OFF_W-1:0] miss_off_q, fill_cnt_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic [TAG_W-1:0] miss_tag_q;

  logic             lk_hit;
  logic [7:0]       lk_data;
  logic             wr_en, tag_we, tag_valid;
  logic [IDX_W-1:0] wr_idx, tag_idx;
  logic [OFF_W-1:0] wr_off;
  logic [7:0]       wr_data;
  logic [TAG_W-1:0] tag_val;

  logic accept, wr_acc, rd_hit, rd_miss;
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;
  assign rd_hit    = accept && !req_write && lk_hit;
  assign rd_miss   = accept && !req_write && !lk_hit;

  always_comb begin
    wr_en     = wr_acc && lk_hit;
    wr_idx    = req_idx;
    wr_off    = req_off;
    wr_data   = req_wdata;
    tag_we    = rd_miss;
    tag_idx   = req_idx;
    tag_val   = req_tag;
    tag_valid = 1'b0;
    if (st_q == ST_FILL) begin
      wr_en     = eng_rx_valid;
      wr_idx    = miss_idx_q;
      wr_off    = fill_cnt_q;
      wr_data   = eng_rx_data;
      tag_we    = eng_done;
      tag_idx   = miss_idx_q;
      tag_val   = miss_tag_q;
      tag_valid = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_BOOT0;
      eng_start_q <= 1'b0;
      frame_q     <= '0;
      ntx_q       <= '0;
      nrx_q       <= '0;
      miss_off_q  <= '0;
      miss_idx_q  <= '0;
      miss_tag_q  <= '0;
      fill_cnt_q  <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      eng_start_q <= 1'b0;
      rsp_valid   <= 1'b0;
      unique case (st_q)
        ST_BOOT0: begin
          eng_start_q <= 1'b1;
          frame_q     <= {OP_RST_EN, 32'h0};
          ntx_q       <= 3'd1;
          nrx_q       <= '0;
          st_q        <= ST_BOOT0_W;
        end
        ST_BOOT0_W: if (eng_done) st_q <= ST_BOOT1;
        ST_BOOT1: begin
          eng_start_q <= 1'b1;
          frame_q     <= {OP_RST, 32'h0};
          ntx_q       <= 3'd1;
          nrx_q       <= '0;
          st_q        <= ST_BOOT1_W;
        end
        ST_BOOT1_W: if (eng_done) st_q <= ST_IDLE;
        ST_IDLE: begin
          if (wr_acc) begin
            eng_start_q <= 1'b1;
            frame_q     <= {OP_PROGRAM, req_a24, req_wdata};
            ntx_q       <= 3'(HDR_BYTES);
            nrx_q       <= '0;
            st_q        <= ST_WRITE;
          end else if (rd_miss) begin
            eng_start_q <= 1'b1;
            frame_q     <= {OP_FAST_READ, line_a24, 8'h00};
            ntx_q       <= 3'(HDR_BYTES);
            nrx_q       <= RXC_W'(LINE_BYTES);
            miss_off_q  <= req_off;
            miss_idx_q  <= req_idx;
            miss_tag_q  <= req_tag;
            fill_cnt_q  <= '0;
            st_q        <= ST_FILL;
          end else if (rd_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= lk_data;
          end
        end
        ST_FILL: begin
          if (eng_rx_valid) begin
            fill_cnt_q <= fill_cnt_q + 1'b1;
            if (fill_cnt_q == miss_off_q) rsp_rdata <= eng_rx_data;
          end
          if (eng_done) begin
            rsp_valid <= 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        ST_WRITE: if (eng_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  psram_line_store #(
    .LINES(LINES), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(req_idx), .lk_tag(req_tag), .lk_off(req_off),
    .lk_hit(lk_hit), .lk_data(lk_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
    .tag_we(tag_we), .tag_idx(tag_idx), .tag_val(tag_val), .tag_valid(tag_valid)
  );

  psram_spi_engine #(
    .SCK_DIV(SCK_DIV), .MAX_RX(LINE_BYTES), .CS_LIMIT_CYC(CS_LIMIT_CYC)
  ) spi_i (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start_q), .tx_frame(frame_q), .tx_bytes(ntx_q), .rx_bytes(nrx_q),
    .done(eng_done), .rx_valid(eng_rx_valid), .rx_data(eng_rx_data),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  // R4
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && lk_hit) |=> rsp_valid);

  // R3
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  // R6
  write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);
endmodule

// File: tb/psram_line_cache_tb_top.sv
`timescale 1ns/1ps
module psram_line_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, spi_sck, spi_cs_n, spi_mosi;
  logic [7:0]  rsp_rdata;
  logic        spi_miso = 1'b0;

  always #2 clk = ~clk;

  psram_line_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, fails = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: computed contents plus written bytes
  logic [7:0] wmem [int];
  function automatic logic [7:0] model(int a);
    if (wmem.exists(a)) return wmem[a];
    return 8'(a ^ (a >> 8) ^ (a >> 16) ^ 32'h5A);
  endfunction

  // bus monitor and slave
  logic [7:0] cur [32];
  logic [7:0] last [32];
  logic [7:0] sh = '0;
  int cur_bits = 0, last_len = 0, txn_cnt = 0;
  int boot_len [2];
  logic [7:0] boot_op [2];
  realtime fall_t = 0, rise_t = -1000;
  realtime min_gap = 1.0e9, max_low = 0;

  always @(negedge spi_cs_n) begin
    cur_bits = 0;
    fall_t = $realtime;
    if (txn_cnt > 0 && ($realtime - rise_t) < min_gap) min_gap = $realtime - rise_t;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    if (cur_bits % 8 == 7 && cur_bits / 8 < 32) cur[cur_bits / 8] = sh;
    cur_bits++;
  end

  always @(negedge spi_sck) if (!spi_cs_n && cur_bits >= 40 && cur[0] == 8'h0B) begin
    int i;
    logic [7:0] b;
    i = cur_bits - 40;
    b = model(int'({cur[1], cur[2], cur[3]}) + i / 8);
    spi_miso = b[7 - (i % 8)];
  end

  always @(posedge spi_cs_n) if (cur_bits > 0) begin
    rise_t = $realtime;
    if ($realtime - fall_t > max_low) max_low = $realtime - fall_t;
    for (int k = 0; k < 32; k++) last[k] = cur[k];
    last_len = cur_bits / 8;
    if (txn_cnt < 2) begin
      boot_len[txn_cnt] = last_len;
      boot_op[txn_cnt]  = cur[0];
    end
    if (last_len == 5 && cur[0] == 8'h02) wmem[int'({cur[1], cur[2], cur[3]})] = cur[4];
    txn_cnt++;
    cur_bits = 0;
  end

  task automatic send(bit wr, int addr, logic [7:0] wd);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 23'(addr); req_wdata = wd;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(int addr, bit exp_hit, string req);
    int t0 = txn_cnt;
    int n = 0;
    send(1'b0, addr, 8'h00);
    if (exp_hit) begin
      chk(req, "hit rsp_valid one cycle after accept", int'(rsp_valid), 1);
      chk(req, "hit data", int'(rsp_rdata), int'(model(addr)));
      chk(req, "hit makes no bus transaction", txn_cnt - t0, 0);
      chk(req, "ready stays high on hit", int'(req_ready), 1);
    end else begin
      chk("R3", "ready low during fill", int'(req_ready), 0);
      while (!rsp_valid && n < 5000) begin @(negedge clk); n++; end
      chk("R3", "miss response seen", int'(rsp_valid), 1);
      chk(req, "miss data", int'(rsp_rdata), int'(model(addr)));
      chk(req, "one transaction per miss", txn_cnt - t0, 1);
      chk("R2", "fill length", last_len, 21);
      chk("R2", "fill opcode", int'(last[0]), 8'h0B);
      chk("R2", "aligned line address", int'({last[1], last[2], last[3]}), addr & ~15);
      chk("R2", "dummy byte", int'(last[4]), 0);
    end
  endtask

  task automatic wr(int addr, logic [7:0] d);
    int t0 = txn_cnt;
    int n = 0;
    send(1'b1, addr, d);
    chk("R6", "no response for write", int'(rsp_valid), 0);
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    chk("R6", "one write transaction", txn_cnt - t0, 1);
    chk("R6", "write length", last_len, 5);
    chk("R6", "write opcode", int'(last[0]), 8'h02);
    chk("R6", "write address", int'({last[1], last[2], last[3]}), addr);
    chk("R6", "write data", int'(last[4]), int'(d));
  endtask

  task automatic t_boot();
    int n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "cs_n high in reset", int'(spi_cs_n), 1);
    chk("R1", "sck low in reset", int'(spi_sck), 0);
    chk("R1", "not ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "not ready during boot", int'(req_ready), 0);
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    chk("R1", "boot transaction count", txn_cnt, 2);
    chk("R1", "reset-enable opcode", int'(boot_op[0]), 8'h66);
    chk("R1", "reset-enable alone", boot_len[0], 1);
    chk("R1", "reset opcode", int'(boot_op[1]), 8'h99);
    chk("R1", "reset alone", boot_len[1], 1);
  endtask

  task automatic t_miss_hit();
    rd(32'h000123, 1'b0, "R2");
    rd(32'h00012F, 1'b1, "R4");
    rd(32'h000120, 1'b1, "R4");
  endtask

  task automatic t_write();
    wr(32'h000125, 8'hC3);
    rd(32'h000125, 1'b1, "R6");
    wr(32'h002345, 8'h3C);
    rd(32'h002346, 1'b0, "R6");
    rd(32'h002345, 1'b1, "R6");
  endtask

  task automatic t_conflict();
    rd(32'h000130, 1'b0, "R5");
    rd(32'h012131, 1'b0, "R5");
    rd(32'h000131, 1'b0, "R5");
    rd(32'h00013F, 1'b1, "R5");
    rd(32'h7FFFFF, 1'b0, "R5");
    rd(32'h7FFFF0, 1'b1, "R5");
  endtask

  task automatic t_timing();
    chk("R7", "cs low time within 8us", int'(max_low <= 8000.0), 1);
    chk("R7", "fill low time near 2.7us", int'(max_low > 2000.0 && max_low < 3000.0), 1);
    chk("R8", "cs high gap at least one SCK period", int'(min_gap >= 16.0), 1);
  endtask

  initial begin
    #(150000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_boot();
    t_miss_hit();
    t_write();
    t_conflict();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule